// File: doc/BRIEF.md
# Converter Serial Readout Controller

This block is the digital side of a sampling converter's serial port. It moves through three phases: converting, sleeping with a finished result, and shifting that result out. An active-low chip select controls the phases. A small counter-based conversion model is part of the block. It takes a start strobe, raises a done strobe after a fixed number of clock cycles, and supplies a result word. The controller captures the result word when the done strobe arrives.

Outside the data phase, the serial data pin carries a ready flag whenever the chip is selected. The pin reads high while a conversion runs and low once a result is waiting. A host lowers chip select, polls this flag, and then clocks out the word most significant bit first. The serial clock pin can work in two ways. The block can drive it from a divided system clock, or a host can drive it. The sensed pin level picks the mode at reset and again on every falling edge of chip select. Raising chip select during the data phase abandons the transfer and starts a fresh conversion. Reading all the bits also starts a fresh conversion.

Top module: `cvt_readout_ctrl`

## Requirements
- R1: While cs_n is high, sdo_oe and sck_oe are both low.
- R2: Outside the data phase, with cs_n low, sdo reads 1 while a conversion is running and 0 once a result is ready.
- R3: After a conversion completes, the block stays asleep as long as cs_n is high. No further conversion starts, and the held result is the one read out later.
- R4: A low cs_n in sleep moves the block into the data phase on the next clock edge. In the data phase, sdo presents the result most significant bit first.
- R5: In external mode, each falling edge of sck_in advances sdo to the next bit. The edge takes effect on the second rising clk edge after it, so the host samples on rising sck_in.
- R6: After the falling clock edge that ends the last of DATA_W bits, a new conversion starts and sdo shows status 1.
- R7: A rising cs_n during the data phase abandons the transfer and starts a new conversion at once. The next readout returns the next conversion's result.
- R8: The level of sck_in selects the clock mode at reset and on each falling edge of cs_n. A level of 1 means internal and 0 means external. The mode is shown on sck_pullup_en, and sck_in has no effect on the mode at any other time.
- R9: In internal mode, during the data phase with cs_n low, sck_oe is high and sck_out starts low and toggles every SCK_HALF clk cycles. Data changes on its falling edges. When the transfer ends or cs_n rises, sck_oe drops at once and sck_out returns low.
- R10: A conversion lasts CONV_CYCLES clk cycles from its start. Its result is RESULT_SEED XOR n, where n counts conversions completed since reset, starting from 0. The first conversion starts at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck_in | input | 1 | Sensed level of the serial clock pin |
| sck_out | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Output enable for sck_out |
| sck_pullup_en | output | 1 | Weak pull-up enable, high in internal mode |
| sdo | output | 1 | Serial data or ready status |
| sdo_oe | output | 1 | Output enable for sdo (low means high impedance) |

## Verification
The hardest conditions to reach are a transfer cut off partway through and a sleep that spans a whole conversion with the chip deselected. Both depend on the host acting at a point in the phase sequence that is visible only through the polled status bit. The bench polls sdo until it falls, clocks out a few bits by hand, and then raises chip select. A later readout must return the next sequence value. This shows that a conversion restarted and that none was skipped or repeated. The mode tests lower chip select with different sensed clock levels and then wiggle the pin while selected, to show that only the falling edge latches the mode.

// File: rtl/ro_pkg.sv
package ro_pkg;

    typedef enum logic [1:0] {
        PH_CONV  = 2'd0,
        PH_SLEEP = 2'd1,
        PH_DATA  = 2'd2
    } ro_phase_e;

    typedef enum logic {
        CK_EXT = 1'b0,
        CK_INT = 1'b1
    } ro_ckmode_e;

    // Ready flag shown on sdo outside the data phase: high while busy.
    function automatic logic status_of(ro_phase_e ph);
        return ph == PH_CONV;
    endfunction

    function automatic int cnt_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ro_conv_stub.sv
module ro_conv_stub #(
    parameter int              DATA_W      = 24,
    parameter int              CONV_CYCLES = 40,
    parameter logic [DATA_W-1:0] SEED      = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              busy,
    output logic [DATA_W-1:0] result
);
    localparam int CW = ro_pkg::cnt_width(CONV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] seq;

    assign done   = busy && (cnt == LAST);
    assign result = seq ^ SEED;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1;
            cnt  <= '0;
            seq  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
                seq  <= seq + DATA_W'(1);
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R10: a finished conversion leaves the model idle unless restarted
    p_done_idles_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy);

endmodule

// File: rtl/ro_sck_gen.sv
module ro_sck_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sck_in,
    output logic sck_out,
    output logic int_fall,
    output logic ext_fall
);
    localparam int HW = ro_pkg::cnt_width(HALF);
    localparam logic [HW-1:0] LASTC = HW'(HALF - 1);

    logic [HW-1:0] cnt;
    logic          s1, s2;

    assign int_fall = run && (cnt == LASTC) && sck_out;
    assign ext_fall = s2 && !s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sck_out <= 1'b0;
            s1      <= 1'b0;
            s2      <= 1'b0;
        end else begin
            s1 <= sck_in;
            s2 <= s1;
            if (!run) begin
                cnt     <= '0;
                sck_out <= 1'b0;
            end else if (cnt == LASTC) begin
                cnt     <= '0;
                sck_out <= !sck_out;
            end else begin
                cnt <= cnt + HW'(1);
            end
        end
    end

    // R9: generated clock rests low when not running
    p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sck_out);
    // R9: clock holds its level between divider terminal counts
    p_half_period_r9: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != LASTC) |=> ($stable(sck_out) || !run));

endmodule

// File: rtl/cvt_readout_ctrl.sv
module cvt_readout_ctrl #(
    parameter int                DATA_W      = 24,
    parameter int                CONV_CYCLES = 40,
    parameter int                SCK_HALF    = 4,
    parameter logic [DATA_W-1:0] RESULT_SEED = 'hA53C96
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck_in,
    output logic sck_out,
    output logic sck_oe,
    output logic sck_pullup_en,
    output logic sdo,
    output logic sdo_oe
);
    import ro_pkg::*;

    localparam int BW = cnt_width(DATA_W);
    localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

    ro_phase_e         phase;
    ro_ckmode_e        mode;
    logic              csn_q;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bitcnt;

    logic              conv_start, conv_done, conv_busy;
    logic [DATA_W-1:0] conv_result;
    logic              int_fall, ext_fall, gen_run;
    logic              csn_fall, shift_evt, last_shift, abort;

    assign csn_fall   = csn_q && !cs_n;
    assign gen_run    = (mode == CK_INT) && (phase == PH_DATA) && !cs_n;
    assign shift_evt  = (phase == PH_DATA) && ((mode == CK_INT) ? int_fall : ext_fall);
    assign last_shift = shift_evt && (bitcnt == LASTBIT);
    assign abort      = (phase == PH_DATA) && cs_n;
    assign conv_start = abort || last_shift;

    ro_conv_stub #(
        .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES), .SEED(RESULT_SEED)
    ) u_core (
        .clk(clk), .rst(rst), .start(conv_start),
        .done(conv_done), .busy(conv_busy), .result(conv_result)
    );

    ro_sck_gen #(.HALF(SCK_HALF)) u_sck (
        .clk(clk), .rst(rst), .run(gen_run), .sck_in(sck_in),
        .sck_out(sck_out), .int_fall(int_fall), .ext_fall(ext_fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_CONV;
            mode   <= ro_ckmode_e'(sck_in);
            csn_q  <= 1'b1;
            shreg  <= '0;
            bitcnt <= '0;
        end else begin
            csn_q <= cs_n;
            if (csn_fall)
                mode <= ro_ckmode_e'(sck_in);
            unique case (phase)
                PH_CONV: if (conv_done) begin
                    phase <= PH_SLEEP;
                    shreg <= conv_result;
                end
                PH_SLEEP: if (!cs_n) begin
                    phase  <= PH_DATA;
                    bitcnt <= '0;
                end
                PH_DATA: if (conv_start) begin
                    phase <= PH_CONV;
                end else if (shift_evt) begin
                    shreg  <= {shreg[DATA_W-2:0], 1'b0};
                    bitcnt <= bitcnt + BW'(1);
                end
                default: phase <= PH_CONV;
            endcase
        end
    end

    assign sdo           = (phase == PH_DATA) ? shreg[DATA_W-1] : status_of(phase);
    assign sdo_oe        = !cs_n;
    assign sck_oe        = gen_run;
    assign sck_pullup_en = (mode == CK_INT);

    // R7: deselect in the data phase restarts conversion at once
    p_abort_restart_r7: assert property (@(posedge clk) disable iff (rst)
        abort |=> (phase == PH_CONV && conv_busy));
    // R3: sleep persists while deselected
    p_sleep_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SLEEP && cs_n) |=> phase == PH_SLEEP);
    // R8: mode follows the pin level sampled at the chip-select fall
    p_mode_latch_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |=> (sck_pullup_en == $past(sck_in)));
    // R6: final bit hands over to a new conversion
    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (last_shift && !cs_n) |=> (phase == PH_CONV && conv_busy));
    // R10: results only arrive while converting
    p_done_in_conv_r10: assert property (@(posedge clk) disable iff (rst)
        conv_done |-> phase == PH_CONV);
    // R1: nothing drives the clock pin while deselected
    p_sck_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck_oe);

endmodule

// File: tb/tb_cvt_readout_ctrl.sv
module tb_cvt_readout_ctrl;
    localparam int W    = 24;
    localparam int CONV = 40;
    localparam int HALF = 4;
    localparam logic [W-1:0] SEED = 24'hA53C96;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck_in = 1'b0;
    logic sck_out, sck_oe, sck_pullup_en, sdo, sdo_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cvt_readout_ctrl #(.DATA_W(W), .CONV_CYCLES(CONV), .SCK_HALF(HALF), .RESULT_SEED(SEED)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sck_pullup_en(sck_pullup_en),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic poll_ready(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (sdo !== 1'b0 && k < 1000);
    endtask

    task automatic read_bits(input int n, output logic [W-1:0] w);
        w = '0;
        for (int i = 0; i < n; i++) begin
            w = {w[W-2:0], sdo};
            sck_in = 1'b1;
            wait_neg(2);
            sck_in = 1'b0;
            wait_neg(3);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; cs_n = 1'b1; sck_in = 1'b0;
        wait_neg(4);
        chk(sdo_oe === 1'b0, "R1 reset sdo_oe", 32'(sdo_oe), 0);
        chk(sck_oe === 1'b0, "R1 reset sck_oe", 32'(sck_oe), 0);
        chk(sck_pullup_en === 1'b0, "R8 reset mode", 32'(sck_pullup_en), 0);
        rst = 1'b0;
    endtask

    task automatic t_status_and_read();
        int k;
        logic [W-1:0] w;
        cs_n = 1'b0;
        #1;
        chk(sdo === 1'b1 && sdo_oe === 1'b1, "R2 busy status", {30'd0, sdo_oe, sdo}, 32'h3);
        poll_ready(k);
        chk(k == CONV, "R10 conversion length", 32'(k), 32'(CONV));
        chk(sdo_oe === 1'b1, "R2 ready status enabled", 32'(sdo_oe), 1);
        @(negedge clk);
        read_bits(W, w);
        chk(w === (SEED ^ W'(0)), "R4 R5 first readout", 32'(w), 32'(SEED));
        chk(sdo === 1'b1, "R6 status after last bit", 32'(sdo), 1);
    endtask

    task automatic t_sleep_hold();
        logic [W-1:0] w;
        cs_n = 1'b1;
        #1;
        chk(sdo_oe === 1'b0, "R1 deselected sdo", 32'(sdo_oe), 0);
        wait_neg(3 * CONV);
        chk(sdo_oe === 1'b0, "R1 still high-z", 32'(sdo_oe), 0);
        sck_in = 1'b0;
        cs_n = 1'b0;
        #1;
        chk(sdo === 1'b0, "R3 asleep with ready status", 32'(sdo), 0);
        @(negedge clk);
        chk(sdo === SEED[W-1], "R4 msb after wake", 32'(sdo), 32'(SEED[W-1]));
        read_bits(W, w);
        chk(w === (SEED ^ W'(1)), "R3 held result", 32'(w), 32'(SEED ^ W'(1)));
    endtask

    task automatic t_abort();
        int k;
        logic [W-1:0] w, exp;
        poll_ready(k);
        @(negedge clk);
        read_bits(5, w);
        exp = (SEED ^ W'(2)) >> (W - 5);
        chk(w === exp, "R5 partial bits", 32'(w), 32'(exp));
        cs_n = 1'b1;
        #1;
        chk(sdo_oe === 1'b0, "R1 abort high-z", 32'(sdo_oe), 0);
        wait_neg(2);
        cs_n = 1'b0;
        #1;
        chk(sdo === 1'b1, "R7 restarted conversion", 32'(sdo), 1);
        poll_ready(k);
        chk(k <= CONV, "R7 ready after restart", 32'(k), 32'(CONV));
        @(negedge clk);
        read_bits(W, w);
        chk(w === (SEED ^ W'(3)), "R7 next result", 32'(w), 32'(SEED ^ W'(3)));
    endtask

    task automatic t_internal();
        logic [W-1:0] w;
        int bits, cyc, last_rise;
        bit prev, per_ok;
        cs_n = 1'b1;
        sck_in = 1'b1;
        wait_neg(CONV + 5);
        cs_n = 1'b0;
        #1;
        chk(sdo === 1'b0, "R2 ready before internal read", 32'(sdo), 0);
        @(negedge clk);
        chk(sck_pullup_en === 1'b1, "R8 internal latched", 32'(sck_pullup_en), 1);
        chk(sck_oe === 1'b1, "R9 clock driven", 32'(sck_oe), 1);
        chk(sck_out === 1'b0, "R9 clock starts low", 32'(sck_out), 0);
        w = '0; bits = 0; cyc = 0; last_rise = -1; prev = 1'b0; per_ok = 1'b1;
        while (bits < W && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (sck_out && !prev) begin
                w = {w[W-2:0], sdo};
                bits++;
                if (last_rise >= 0 && cyc - last_rise != 2 * HALF) per_ok = 1'b0;
                last_rise = cyc;
            end
            prev = sck_out;
        end
        chk(per_ok, "R9 clock period", 32'(per_ok), 1);
        chk(w === (SEED ^ W'(4)), "R9 internal readout", 32'(w), 32'(SEED ^ W'(4)));
        wait_neg(2 * HALF + 2);
        chk(sck_oe === 1'b0 && sdo === 1'b1, "R6 end of internal read", {30'd0, sck_oe, sdo}, 32'h1);
    endtask

    task automatic t_internal_abort();
        int k;
        poll_ready(k);
        @(negedge clk);
        chk(sck_oe === 1'b1, "R9 clock driven again", 32'(sck_oe), 1);
        wait_neg(3);
        cs_n = 1'b1;
        #1;
        chk(sck_oe === 1'b0 && sdo_oe === 1'b0, "R1 R9 release on deselect", {30'd0, sck_oe, sdo_oe}, 0);
        @(negedge clk);
        chk(sck_out === 1'b0, "R9 clock idles low", 32'(sck_out), 0);
    endtask

    task automatic t_relatch();
        sck_in = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        chk(sck_pullup_en === 1'b0, "R8 relatch external", 32'(sck_pullup_en), 0);
        sck_in = 1'b1;
        wait_neg(2);
        chk(sck_pullup_en === 1'b0, "R8 level ignored while low", 32'(sck_pullup_en), 0);
        cs_n = 1'b1;
        wait_neg(2);
        cs_n = 1'b0;
        @(negedge clk);
        chk(sck_pullup_en === 1'b1, "R8 relatch internal", 32'(sck_pullup_en), 1);
        cs_n = 1'b1;
        sck_in = 1'b0;
        wait_neg(2);
        cs_n = 1'b0;
        @(negedge clk);
        chk(sck_pullup_en === 1'b0, "R8 relatch external again", 32'(sck_pullup_en), 0);
        cs_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_status_and_read();
        t_sleep_hold();
        t_abort();
        t_internal();
        t_internal_abort();
        t_relatch();
        wait_neg(4);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule